// File: doc/BRIEF.md
# Event-Pending Interrupt Aggregator

This block collects hardware events and turns them into three level interrupt requests. A source reports an event by presenting an encoded event number together with a one-cycle strobe. The block latches each event as a bit in one of three 32-bit pending words. Each of the three interrupt lines has its own bank of three 32-bit enable masks, one mask per pending word. A line requests service while any pending bit is enabled in that line's masks. The three lines map to three processor priority levels. Line A (index 0) goes to the highest level, line B (index 1) to the middle level and line C (index 2) to the lowest.

Software reaches the block through a simple register port. It has a write strobe, a word address and write data. Read data is combinational on the address. Software reads the pending words to find out which events occurred. It acknowledges events by writing ones to the bits it wants cleared in a pending word. It programs the mask words to pick which events reach which line.

Top module: `evt_irq_agg`

## Requirements
- R1: While `rst_ni` is low, every pending word, every mask word and every `irq_o` line is zero.
- R2: A strobed event code sets one bit in the pending words at the next clock edge. Code bits 6:5 select pending word 0, 1 or 2, and code bits 4:0 select the bit within that word. The bit reads back as 1 from the following cycle.
- R3: A register write to pending address 0, 1 or 2 clears each bit of that word whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When an event and a software clear target the same pending bit in the same cycle, the bit ends up set.
- R5: `irq_o[L]` is 1 in the cycle after one in which the AND of some pending word with line L's mask word for that pending word is nonzero. Index 0 is line A (highest priority), 1 is B, 2 is C.
- R6: `irq_o[L]` is 0 in the cycle after one in which that AND is zero for all three words. A mask change therefore takes effect one cycle after it is written, in the same way as a clear.
- R7: An event code whose bits 6:5 equal 3 changes no pending bit.
- R8: Register map by word address:
  - 0 to 2: pending words.
  - 3 to 5: line A masks for words 0 to 2.
  - 6 to 8: line B masks.
  - 9 to 11: line C masks.
  - Mask writes store the full 32-bit value.
  - Addresses 12 to 15 read as zero, and writes to them change nothing.
- R9: Reading any address has no side effect: pending and mask contents are unchanged by reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously by the system |
| evt_vld_i | input | 1 | Event strobe, one event per cycle |
| evt_code_i | input | 7 | Event code: bits 6:5 word select, bits 4:0 bit select |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 3 | Interrupt levels: [0] line A, [1] line B, [2] line C |

## Verification
The bench aims at the following corner cases:
- An event and a clear hitting the same bit in the same cycle. A design that let the clear win would lose the event and leave the line low.
- Clearing one enabled bit while other enabled bits are still pending in other words. A design that dropped the line on any clear would lose a pending request.
- Writing a mask to zero while its pending bit is still set. A design that only evaluated masks on new events would hold the line high forever.
- Reserved word-select codes and writes to unmapped addresses. A decoder that folded these onto real words would corrupt state.

A behavioural reference model runs beside the design. It is compared on the line outputs and read data every cycle, including a long stretch of mixed random events, clears and mask writes.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Default geometry shared by the aggregator and its sub-blocks.
  localparam int unsigned DEF_WORDS  = 3;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_LINES  = 3;
  localparam int unsigned DEF_CODE_W = 7;
  localparam int unsigned DEF_ADDR_W = 4;

  // Line index ordering: lower index means higher processor priority.
  typedef enum logic [1:0] {
    LINE_A = 2'd0,
    LINE_B = 2'd1,
    LINE_C = 2'd2
  } line_e;
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned WORDS  = evt_irq_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = evt_irq_pkg::DEF_WORD_W,
  parameter int unsigned CODE_W = evt_irq_pkg::DEF_CODE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          evt_vld_i,
  input  logic [CODE_W-1:0]             evt_code_i,
  input  logic [WORDS-1:0]              clr_en_i,
  input  logic [WORD_W-1:0]             clr_data_i,
  output logic [WORDS-1:0][WORD_W-1:0]  pend_o
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned SEL_W = CODE_W - BIT_W;

  logic [SEL_W-1:0] sel;
  logic [BIT_W-1:0] bidx;

  assign sel  = evt_code_i[CODE_W-1 -: SEL_W];
  assign bidx = evt_code_i[BIT_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] set_v, clr_v, nxt_v, pend_q;
    logic              upd;

    // next-state: set wins over clear on the same bit
    always_comb begin
      set_v = '0;
      if (evt_vld_i && (sel == SEL_W'(w))) begin
        set_v = WORD_W'(1) << bidx;
      end
      clr_v = clr_en_i[w] ? clr_data_i : '0;
      nxt_v = (pend_q & ~clr_v) | set_v;
      upd   = (|set_v) | (|clr_v);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
      end else if (upd) begin
        pend_q <= nxt_v;
      end
    end

    assign pend_o[w] = pend_q;
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int unsigned WORDS  = evt_irq_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = evt_irq_pkg::DEF_WORD_W,
  parameter int unsigned LINES  = evt_irq_pkg::DEF_LINES
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [LINES-1:0][WORDS-1:0]              we_i,
  input  logic [WORD_W-1:0]                        wdata_i,
  output logic [LINES-1:0][WORDS-1:0][WORD_W-1:0]  mask_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] mask_q, mask_d;

      always_comb begin
        mask_d = we_i[l][w] ? wdata_i : mask_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mask_q <= '0;
        end else if (we_i[l][w]) begin
          mask_q <= mask_d;
        end
      end

      assign mask_o[l][w] = mask_q;
    end
  end
endmodule

// File: rtl/evt_irq_eval.sv
module evt_irq_eval #(
  parameter int unsigned WORDS  = evt_irq_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = evt_irq_pkg::DEF_WORD_W,
  parameter int unsigned LINES  = evt_irq_pkg::DEF_LINES
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [WORDS-1:0][WORD_W-1:0]             pend_i,
  input  logic [LINES-1:0][WORDS-1:0][WORD_W-1:0]  mask_i,
  output logic [LINES-1:0]                         irq_o
);
  logic [LINES-1:0] hit_d, irq_q;
  logic             upd;

  // masked OR over every pending word, per line
  always_comb begin
    hit_d = '0;
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WORDS; w++) begin
        hit_d[l] = hit_d[l] | (|(pend_i[w] & mask_i[l][w]));
      end
    end
    upd = (hit_d != irq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
    end else if (upd) begin
      irq_q <= hit_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int unsigned WORDS  = evt_irq_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = evt_irq_pkg::DEF_WORD_W,
  parameter int unsigned LINES  = evt_irq_pkg::DEF_LINES,
  parameter int unsigned CODE_W = evt_irq_pkg::DEF_CODE_W,
  parameter int unsigned ADDR_W = evt_irq_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_vld_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [LINES-1:0]  irq_o
);
  localparam int unsigned MASK_BASE = WORDS;

  logic [WORDS-1:0][WORD_W-1:0]             pend_w;
  logic [LINES-1:0][WORDS-1:0][WORD_W-1:0]  mask_w;
  logic [WORDS-1:0]                         clr_en;
  logic [LINES-1:0][WORDS-1:0]              mask_we;
  logic [WORD_W-1:0]                        rdata;

  // address decode and read mux; unmapped addresses read zero
  always_comb begin
    clr_en  = '0;
    mask_we = '0;
    rdata   = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(w)) begin
        clr_en[w] = reg_we_i;
        rdata     = pend_w[w];
      end
    end
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (reg_addr_i == ADDR_W'(MASK_BASE + l * WORDS + w)) begin
          mask_we[l][w] = reg_we_i;
          rdata         = mask_w[l][w];
        end
      end
    end
  end

  assign reg_rdata_o = rdata;

  evt_pend_bank #(.WORDS(WORDS), .WORD_W(WORD_W), .CODE_W(CODE_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_vld_i  (evt_vld_i),
    .evt_code_i (evt_code_i),
    .clr_en_i   (clr_en),
    .clr_data_i (reg_wdata_i),
    .pend_o     (pend_w)
  );

  evt_mask_bank #(.WORDS(WORDS), .WORD_W(WORD_W), .LINES(LINES)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_w)
  );

  evt_irq_eval #(.WORDS(WORDS), .WORD_W(WORD_W), .LINES(LINES)) u_eval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_w),
    .mask_i (mask_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int unsigned WORDS  = evt_irq_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = evt_irq_pkg::DEF_WORD_W,
  parameter int unsigned LINES  = evt_irq_pkg::DEF_LINES,
  parameter int unsigned CODE_W = evt_irq_pkg::DEF_CODE_W
) (
  input logic                                     clk_i,
  input logic                                     rst_ni,
  input logic                                     evt_vld_i,
  input logic [CODE_W-1:0]                        evt_code_i,
  input logic                                     reg_we_i,
  input logic [WORDS-1:0][WORD_W-1:0]             pend_i,
  input logic [LINES-1:0][WORDS-1:0][WORD_W-1:0]  mask_i,
  input logic [LINES-1:0]                         irq_i
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned SEL_W = CODE_W - BIT_W;

  logic [WORDS*WORD_W-1:0] pflat;
  logic [LINES-1:0]        hit_c;
  logic                    sel_ok;
  int unsigned             idx;

  assign pflat  = pend_i;
  assign sel_ok = (int'(evt_code_i[CODE_W-1 -: SEL_W]) < WORDS);
  assign idx    = sel_ok ? (int'(evt_code_i[CODE_W-1 -: SEL_W]) * WORD_W
                            + int'(evt_code_i[BIT_W-1:0])) : 0;

  always_comb begin
    hit_c = '0;
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WORDS; w++) begin
        hit_c[l] = hit_c[l] | (|(pend_i[w] & mask_i[l][w]));
      end
    end
  end

  AST_EVT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && sel_ok) |=> pflat[$past(idx)]);  // R2

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && !sel_ok && !reg_we_i) |=> $stable(pend_i));  // R7

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(mask_i));  // R9

  for (genvar l = 0; l < LINES; l++) begin : g_line
    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_c[l] |=> irq_i[l]);  // R5
    AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_c[l] |=> !irq_i[l]);  // R6
  end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .WORDS(WORDS), .WORD_W(WORD_W), .LINES(LINES), .CODE_W(CODE_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_vld_i  (evt_vld_i),
  .evt_code_i (evt_code_i),
  .reg_we_i   (reg_we_i),
  .pend_i     (pend_w),
  .mask_i     (mask_w),
  .irq_i      (irq_o)
);

// File: tb/evt_irq_agg_tb_top.sv
`timescale 1ns/1ps
module evt_irq_agg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        evt_vld_i = 1'b0;
  logic [6:0]  evt_code_i = '0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  irq_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference state
  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];
  logic [2:0]  m_irq;

  always #2.5 clk_i = ~clk_i;

  evt_irq_agg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_vld_i(evt_vld_i), .evt_code_i(evt_code_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a < 3) return m_pend[a];
    if (a < 12) return m_mask[(a - 3) / 3][(a - 3) % 3];
    return 32'h0;
  endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // model update and comparison every cycle
  always @(posedge clk_i) begin
    logic [2:0] nirq;
    if (!rst_ni) begin
      for (int w = 0; w < 3; w++) begin
        m_pend[w] = '0;
        for (int l = 0; l < 3; l++) m_mask[l][w] = '0;
      end
      m_irq = '0;
    end else begin
      nirq = '0;
      for (int l = 0; l < 3; l++)
        for (int w = 0; w < 3; w++)
          if ((m_pend[w] & m_mask[l][w]) != 0) nirq[l] = 1'b1;
      if (reg_we_i) begin
        if (reg_addr_i < 3) m_pend[reg_addr_i] = m_pend[reg_addr_i] & ~reg_wdata_i;
        else if (reg_addr_i < 12) m_mask[(reg_addr_i - 3) / 3][(reg_addr_i - 3) % 3] = reg_wdata_i;
      end
      if (evt_vld_i && evt_code_i[6:5] != 2'd3)
        m_pend[evt_code_i[6:5]][evt_code_i[4:0]] = 1'b1;
      m_irq = nirq;
    end
    started = 1'b1;
    #1;
    if (!done) begin
      n_checks++;
      if (irq_o !== m_irq) begin
        n_errors++;
        $display("FAIL %s irq_o act=%b exp=%b", tag, irq_o, m_irq);
      end
      n_checks++;
      if (reg_rdata_o !== m_read(reg_addr_i)) begin
        n_errors++;
        $display("FAIL %s rdata[%0d] act=%h exp=%h", tag, reg_addr_i, reg_rdata_o, m_read(reg_addr_i));
      end
    end
  end

  task automatic cyc(input bit vld, input logic [6:0] code, input bit we,
                     input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk_i);
    evt_vld_i = vld; evt_code_i = code; reg_we_i = we;
    reg_addr_i = addr; reg_wdata_i = data;
  endtask

  task automatic idle(input logic [3:0] addr);
    cyc(1'b0, 7'd0, 1'b0, addr, 32'h0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    // R1: everything reads zero while reset is held
    tag = "R1";
    for (int a = 0; a < 16; a++) idle(4'(a));
    @(negedge clk_i) rst_ni = 1'b1;

    // R8: program masks, probe unmapped addresses
    tag = "R8";
    cyc(0, 0, 1, 4'd3, 32'h0000_0001);   // A word0
    cyc(0, 0, 1, 4'd7, 32'h8000_0000);   // B word1
    cyc(0, 0, 1, 4'd11, 32'hFFFF_0000);  // C word2
    cyc(0, 0, 1, 4'd12, 32'hDEAD_BEEF);
    cyc(0, 0, 1, 4'd15, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) idle(4'(a));

    // R2 / R5: events into each word, per-line
    tag = "R2_R5";
    cyc(1, 7'd0, 0, 4'd0, 0);            // word0 bit0 -> A
    idle(4'd0); idle(4'd0);
    cyc(1, 7'd63, 0, 4'd1, 0);           // word1 bit31 -> B
    idle(4'd1); idle(4'd1);
    cyc(1, 7'd80, 0, 4'd2, 0);           // word2 bit16 -> C
    cyc(1, 7'd5, 0, 4'd0, 0);            // unmasked bit
    idle(4'd2); idle(4'd0);

    // R3 / R6: clear word0 bit0 only, A drops, B/C stay
    tag = "R3_R6";
    cyc(0, 0, 1, 4'd0, 32'h0000_0001);
    idle(4'd0); idle(4'd0);

    // R4: same-cycle event and clear on word0 bit3
    tag = "R4";
    cyc(1, 7'd3, 1, 4'd0, 32'h0000_0008);
    idle(4'd0); idle(4'd0);

    // R7: reserved word-select codes
    tag = "R7";
    for (int c = 96; c < 128; c += 5) cyc(1, 7'(c), 0, 4'(c % 3), 0);
    idle(4'd0); idle(4'd1); idle(4'd2);

    // R9: repeated reads leave state unchanged
    tag = "R9";
    for (int i = 0; i < 6; i++) idle(4'(i % 3));

    // R6: mask change drops line B while bit stays pending
    tag = "R6";
    cyc(0, 0, 1, 4'd7, 32'h0);
    idle(4'd1); idle(4'd1);

    // mixed traffic
    tag = "R2_R3_R5_R6";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[7:1], r[8] & r[9], 4'(r[13:10] % 13),
          r[14] ? {r[31:16], r[31:16]} : 32'(1) << r[20:16]);
    end
    idle(4'd0);
    idle(4'd0);
    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 5);
    done = 1'b1;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
  end
endmodule